// File: doc/BRIEF.md
# Overload Trip Timer for a Powered Ethernet Port

This block decides when a powered port has to be switched off because its load draws too much current. Analog comparators outside the block provide two flags. One says the output current is above the cut threshold for the power granted to the port. The other says the current limiter is active. A third flag marks a high-power (class 4) load. A free-running 1 ms tick paces all timing.

The block keeps an asymmetric leaky integrator. Each tick spent above the cut threshold adds one. Below the threshold, the integrator drains by one for every sixteen ticks. When it reaches the trip level (60 ms by default), the block raises a fault. For high-power loads, a second timer measures how long the current stays at the limit without a break. If that lasts for the limit window (15 ms by default), it also trips the port, which protects the pass switch.

A trip produces a single-cycle pulse and sets a sticky fault flag. While the fault is held, both timers are frozen. Dropping the port enable clears the fault and both timers.

Top module: `overload_guard`

## Requirements
- R1: After a synchronous active-low reset, `trip_pulse` and `trip_latched` are 0. Both timers start from zero, so a fresh trip needs a full trip window.
- R2: With `over_cut` high on every tick, the fault is raised on the TRIP_MS-th tick (60) and not earlier. The integrator never counts past the trip level.
- R3: Ticks with `over_cut` low drain the integrator by one on every sixteenth such tick (one step per 2^DIV_LOG2 ticks).
- R4: The integrator saturates at zero. Any number of below-threshold ticks from zero still leaves a full TRIP_MS ticks needed to trip.
- R5: A tick with `over_cut` high restarts the drain prescaler. Two runs of 15 below-threshold ticks separated by an above tick cause no drain step.
- R6: With `hi_class` and `at_limit` both high, the fault is raised on the LIMIT_MS-th consecutive tick (15) and not earlier.
- R7: The limit timer returns to zero in any clock cycle where `at_limit` or `hi_class` is low. It does not integrate across breaks.
- R8: `at_limit` has no effect when `hi_class` is low.
- R9: A trip drives `trip_pulse` high for exactly one cycle. `trip_latched` then stays high, and the timers stay frozen, for as long as `port_en` is high.
- R10: Driving `port_en` low clears `trip_latched` and both timers.
- R11: Ticks that arrive while `port_en` is low have no effect.
- R12: Timers only advance on `tick_ms`. Flags held high between ticks do not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| port_en | input | 1 | Port is powered; low clears all state |
| over_cut | input | 1 | Output current above the cut threshold |
| at_limit | input | 1 | Current limiter active |
| hi_class | input | 1 | Load is class 4 |
| trip_pulse | output | 1 | One-cycle fault pulse |
| trip_latched | output | 1 | Sticky fault flag, cleared by `port_en` low |

## Verification
Internal state can only be seen through the number of ticks the block needs before `trip_latched` rises. A wrong integrator level, a prescaler phase that was not restarted, or a limit timer that was not cleared each changes that count. The error therefore shows up at most one trip window later, as an early or missing fault. The bench first builds a known level from arithmetic (up ticks minus drain steps, floored at zero). It then checks that the fault stays low one tick before the predicted count and rises exactly on it. This exposes off-by-one and saturation faults within a few dozen ticks.

// File: rtl/ovl_pkg.sv
// Shared helpers for the overload trip timer.
// Assumes counters are sized to hold their own saturation limit.
package ovl_pkg;

    // Width needed to hold the values 0..maxv
    function automatic int unsigned cnt_w(input int unsigned maxv);
        return $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/leak_integrator.sv
// Asymmetric leaky integrator. It counts up one per tick above threshold
// and drains one per 2^DIV_LOG2 ticks below threshold, saturating at 0
// and at MAXV. Assumes tick is a single-cycle pulse. While hold is high
// the state is frozen. clear wipes the state synchronously.
module leak_integrator #(
    parameter int unsigned MAXV     = 60,
    parameter int unsigned DIV_LOG2 = 4,
    parameter int unsigned W        = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         hold,
    input  logic         tick,
    input  logic         above,
    output logic [W-1:0] level,
    output logic         full
);
    localparam logic [W-1:0] TOP = W'(MAXV);

    logic [DIV_LOG2-1:0] pre;

    // Level and drain prescaler update, once per accepted tick
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            level <= '0;
            pre   <= '0;
        end else if (tick && !hold) begin
            if (above) begin
                pre <= '0;
                if (level != TOP) level <= level + 1'b1;
            end else begin
                pre <= pre + 1'b1;
                if (pre == '1 && level != '0) level <= level - 1'b1;
            end
        end
    end

    // Trip level reached
    always_comb full = (level == TOP);

endmodule

// File: rtl/limit_timer.sv
// Continuous-at-limit timer. It counts ticks while armed, saturates at
// MAXV and returns to zero in any cycle where armed is low. Assumes
// tick is a single-cycle pulse. hold freezes the count.
module limit_timer #(
    parameter int unsigned MAXV = 15,
    parameter int unsigned W    = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         hold,
    input  logic         tick,
    input  logic         armed,
    output logic [W-1:0] level,
    output logic         full
);
    localparam logic [W-1:0] TOP = W'(MAXV);

    // Count consecutive armed ticks, restart on any break
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !armed) begin
            level <= '0;
        end else if (tick && !hold && level != TOP) begin
            level <= level + 1'b1;
        end
    end

    // Window elapsed
    always_comb full = (level == TOP);

endmodule

// File: rtl/trip_latch.sv
// Fault latch. It raises a one-cycle pulse on the first cycle an event
// is seen and then holds a sticky flag until clear. Assumes evt may
// stay high for many cycles.
module trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic evt,
    output logic pulse,
    output logic latched
);
    // Edge pulse and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pulse   <= 1'b0;
            latched <= 1'b0;
        end else begin
            pulse   <= evt && !latched;
            latched <= latched || evt;
        end
    end

endmodule

// File: rtl/overload_guard.sv
// Overload trip timer top. It combines the leaky overcurrent integrator
// and the class-4 limit timer into one fault. Assumes the comparator
// flags are synchronous to clk and tick_ms is a single-cycle pulse.
// Low port_en clears everything. A latched fault freezes both timers.
module overload_guard #(
    parameter int unsigned TRIP_MS  = 60,
    parameter int unsigned LIMIT_MS = 15,
    parameter int unsigned DIV_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic port_en,
    input  logic over_cut,
    input  logic at_limit,
    input  logic hi_class,
    output logic trip_pulse,
    output logic trip_latched
);
    import ovl_pkg::*;

    localparam int unsigned IW = cnt_w(TRIP_MS);
    localparam int unsigned LW = cnt_w(LIMIT_MS);

    logic          clear;
    logic          armed;
    logic          int_full;
    logic          lim_full;
    logic [IW-1:0] int_level;
    logic [LW-1:0] lim_level;

    // Port-level control decode
    always_comb begin
        clear = !port_en;
        armed = at_limit && hi_class;
    end

    leak_integrator #(
        .MAXV(TRIP_MS), .DIV_LOG2(DIV_LOG2), .W(IW)
    ) u_int (
        .clk(clk), .rst_n(rst_n), .clear(clear), .hold(trip_latched),
        .tick(tick_ms), .above(over_cut), .level(int_level), .full(int_full)
    );

    limit_timer #(
        .MAXV(LIMIT_MS), .W(LW)
    ) u_lim (
        .clk(clk), .rst_n(rst_n), .clear(clear), .hold(trip_latched),
        .tick(tick_ms), .armed(armed), .level(lim_level), .full(lim_full)
    );

    trip_latch u_trip (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .evt(int_full || lim_full),
        .pulse(trip_pulse), .latched(trip_latched)
    );

endmodule

// File: rtl/overload_guard_chk.sv
// Temporal checks for overload_guard. Bound to the top, it observes the
// ports and the two timer levels.
module overload_guard_chk #(
    parameter int unsigned TRIP_MS  = 60,
    parameter int unsigned LIMIT_MS = 15,
    parameter int unsigned IW       = 6,
    parameter int unsigned LW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_ms,
    input logic          port_en,
    input logic          at_limit,
    input logic          hi_class,
    input logic          trip_pulse,
    input logic          trip_latched,
    input logic [IW-1:0] int_level,
    input logic [LW-1:0] lim_level
);
    // R2
    int_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_level <= IW'(TRIP_MS));
    // R3
    drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && int_level != '0 |=> int_level >= $past(int_level) - 1);
    // R6
    lim_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_level <= LW'(LIMIT_MS));
    // R7
    lim_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_limit && hi_class) |=> lim_level == '0);
    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse |=> !trip_pulse);
    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_latched && port_en |=> trip_latched);
    // R9
    latch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_latched) |-> trip_pulse);
    // R10
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !trip_latched && int_level == '0 && lim_level == '0);
    // R12
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && !tick_ms |=> $stable(int_level));
endmodule

bind overload_guard overload_guard_chk #(
    .TRIP_MS(TRIP_MS), .LIMIT_MS(LIMIT_MS), .IW(IW), .LW(LW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .port_en(port_en),
    .at_limit(at_limit), .hi_class(hi_class), .trip_pulse(trip_pulse),
    .trip_latched(trip_latched), .int_level(int_level), .lim_level(lim_level)
);

// File: tb/sim_overload_guard.sv
`timescale 1ns/1ps
module sim_overload_guard;
    localparam int TRIP = 60;
    localparam int LIM  = 15;
    localparam int DIV  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0, port_en = 1'b0, over_cut = 1'b0;
    logic at_limit = 1'b0, hi_class = 1'b0;
    logic trip_pulse, trip_latched;

    int errors = 0, checks = 0, pulses = 0;

    always #4 clk = ~clk;

    overload_guard u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .port_en(port_en),
        .over_cut(over_cut), .at_limit(at_limit), .hi_class(hi_class),
        .trip_pulse(trip_pulse), .trip_latched(trip_latched)
    );

    always @(negedge clk) if (rst_n && trip_pulse) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n, input bit oc, input bit lim, input bit c4);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            over_cut = oc; at_limit = lim; hi_class = c4; tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
            idle(2);
        end
    endtask

    task automatic fresh();
        @(negedge clk);
        port_en = 1'b0; over_cut = 1'b0; at_limit = 1'b0; hi_class = 1'b0;
        idle(2);
        port_en = 1'b1;
        idle(1);
    endtask

    // Trip must not happen after n-1 ticks and must happen on tick n
    task automatic trip_after(input int n, input bit oc, input bit lim,
                              input bit c4, input string req);
        int p0;
        p0 = pulses;
        ticks(n - 1, oc, lim, c4);
        chk({req, " early"}, trip_latched, 0);
        ticks(1, oc, lim, c4);
        chk({req, " latched"}, trip_latched, 1);
        chk({req, " one pulse"}, pulses - p0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lvl, p0;
        // R1: reset state, even with port enabled and flags set
        port_en = 1'b1; over_cut = 1'b1; tick_ms = 1'b1;
        idle(3);
        tick_ms = 1'b0;
        chk("R1 pulse", trip_pulse, 0);
        chk("R1 latched", trip_latched, 0);
        rst_n = 1'b1;
        idle(2);
        trip_after(TRIP, 1, 0, 0, "R1 R2 full window");

        // R9: remains latched, single pulse, timers frozen
        p0 = pulses;
        ticks(40, 0, 0, 0);
        chk("R9 stays latched", trip_latched, 1);
        chk("R9 no extra pulse", pulses - p0, 0);

        // R10: disable clears the latch, full window needed again
        fresh();
        chk("R10 cleared", trip_latched, 0);
        ticks(50, 1, 0, 0);
        fresh();
        trip_after(TRIP, 1, 0, 0, "R10 mid clear");

        // R11: ticks while disabled ignored
        @(negedge clk); port_en = 1'b0;
        ticks(70, 1, 1, 1);
        chk("R11 disabled", trip_latched, 0);
        @(negedge clk); port_en = 1'b1;
        trip_after(TRIP, 1, 0, 0, "R11 after enable");

        // R12: flags without ticks do not count
        fresh();
        over_cut = 1'b1; at_limit = 1'b1; hi_class = 1'b1;
        idle(300);
        chk("R12 no tick", trip_latched, 0);
        at_limit = 1'b0; hi_class = 1'b0;
        trip_after(TRIP, 1, 0, 0, "R12 window");

        // R3 sweep: up n, down d, expected level = max(0, n - d/16)
        for (int n = 10; n <= 50; n += 10) begin
            for (int d = 0; d <= 64; d += 8) begin
                fresh();
                ticks(n, 1, 0, 0);
                ticks(d, 0, 0, 0);
                lvl = n - d / DIV;
                if (lvl < 0) lvl = 0;
                trip_after(TRIP - lvl, 1, 0, 0, "R3 drain");
            end
        end

        // R4: saturation at zero
        fresh();
        ticks(5, 1, 0, 0);
        ticks(200, 0, 0, 0);
        trip_after(TRIP, 1, 0, 0, "R4 floor");

        // R5: above tick restarts prescaler
        fresh();
        ticks(30, 1, 0, 0);
        ticks(15, 0, 0, 0);
        ticks(1, 1, 0, 0);
        ticks(15, 0, 0, 0);
        trip_after(TRIP - 31, 1, 0, 0, "R5 prescaler restart");

        // R6: class-4 limit window
        fresh();
        trip_after(LIM, 0, 1, 1, "R6 limit");

        // R7: any break restarts the limit timer
        for (int h = 1; h < LIM; h++) begin
            fresh();
            ticks(h, 0, 1, 1);
            @(negedge clk); at_limit = 1'b0;
            @(negedge clk);
            trip_after(LIM, 0, 1, 1, "R7 break");
        end
        fresh();
        ticks(10, 0, 1, 1);
        @(negedge clk); hi_class = 1'b0;
        @(negedge clk);
        trip_after(LIM, 0, 1, 1, "R7 class drop");

        // R8: limit ignored for lower classes
        fresh();
        ticks(40, 0, 1, 0);
        chk("R8 no class", trip_latched, 0);
        chk("R8 no pulse", trip_pulse, 0);
        trip_after(TRIP, 1, 1, 0, "R8 integrator only");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule